// File: doc/BRIEF.md
# SIMD Lane Flag Reduction Unit

This unit folds the condition flags of a packed SIMD flag register into one 4-bit group, which then becomes the top nibble of a processor status word. The flag register holds eight 4-bit lanes, and lane k sits at bits [4k+3:4k]. The unit supports three operations. The first takes the bitwise AND across the lanes that take part. The second takes the bitwise OR across the same lanes. The third copies one chosen lane as it is. The element size decides which lanes take part. Byte elements use every lane, halfword elements use the odd lanes, and word elements use lanes 3 and 7.

The caller presents the flag register, the current status word, an element-size code, a lane selector and an operation code, and pulses `start` for one cycle. On the next cycle the unit returns the updated status word together with a one-cycle `done` pulse. A reserved element-size code or a reserved operation code is refused. In that case the unit returns the status word unchanged and raises `undef` for the same cycle as `done`.

Top module: `lane_flag_reduce`

## Requirements
- R1: While the synchronous, active-high `rst` is high, `status_out`, `done` and `undef` are all zero, and a `start` presented during reset has no effect.
- R2: Each `start` produces exactly one `done` pulse, in the clock cycle that follows it, and `done` is never high without a `start` in the cycle before. Back-to-back starts produce back-to-back pulses.
- R3: With size code 0 (byte), op code 0 (AND) gives the bitwise AND of all eight lanes, and op code 1 (OR) gives their bitwise OR.
- R4: With size code 1 (halfword), AND and OR combine only lanes 1, 3, 5 and 7, which are the nibbles at bits 7:4, 15:12, 23:20 and 31:28. The even lanes have no effect on the result.
- R5: With size code 2 (word), AND and OR combine only lanes 3 and 7, at bits 15:12 and 31:28. All other lanes have no effect on the result.
- R6: On every accepted operation, the 4-bit result replaces bits 31:28 of `status_out`. Bits 27:0 are copied from the `status_in` value that was sampled with `start`.
- R7: Op code 2 (extract) with size code 0 returns the nibble that starts at bit selector×4.
- R8: Extract with size code 1 returns the nibble that starts at bit (selector mod 4)×8+4. Selector bit 2 has no effect.
- R9: Extract with size code 2 returns the nibble that starts at bit (selector mod 2)×16+12. Selector bits 2:1 have no effect.
- R10: Size code 3 raises `undef` together with `done`, and `status_out` takes the `status_in` value sampled with `start`, unchanged.
- R11: Op code 3 behaves as R10 does for any size code. For accepted operations `undef` stays low.
- R12: In cycles without `start`, `status_out` holds its last value whatever the other inputs do, and `undef` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| flags_in | input | 32 | Packed lane flags, lane k at bits [4k+3:4k] |
| status_in | input | 32 | Current status word |
| elem_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| lane_sel | input | 3 | Lane selector for extract |
| op_sel | input | 2 | 0 AND, 1 OR, 2 extract, 3 reserved |
| status_out | output | 32 | Updated status word |
| done | output | 1 | One-cycle result strobe |
| undef | output | 1 | Reserved code seen, valid with done |

## Verification
The bench drives flag patterns in which only the lanes that should be excluded disagree with the lanes that count. A design that folds even lanes into halfword or word results, or that uses the wrong lane of a pair or quad, shows a zero where an all-ones nibble is expected, or the reverse. Every selector value is swept under every size. This exposes a design that forgets the modulo on the selector or the +4/+12 offsets, because that design returns the wrong digit from a flag register in which each nibble holds its own lane number. The reserved size and operation codes, back-to-back starts, a mid-run reset and idle cycles with changing inputs catch four kinds of fault: a design that still writes the status word on refusal, one that drops or repeats `done`, one that keeps stale outputs through reset, and one that updates the word without a request.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_RSVD = 2'd3
   } esz_e;

   typedef enum logic [1:0] {
      FOP_ALL  = 2'd0,
      FOP_ANY  = 2'd1,
      FOP_PICK = 2'd2,
      FOP_RSVD = 2'd3
   } fop_e;
endpackage

// File: rtl/lfr_lane_mask.sv
module lfr_lane_mask #(
   parameter int NUM_LANES = 8
) (
   input  logic [1:0]           size_code,
   output logic [NUM_LANES-1:0] part
);
   // A lane takes part when it is the last lane of its element group.
   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      localparam bit IN_HALF = ((k + 1) % 2) == 0;
      localparam bit IN_WORD = ((k + 1) % 4) == 0;
      always_comb begin
         case (size_code)
            lfr_pkg::ESZ_BYTE: part[k] = 1'b1;
            lfr_pkg::ESZ_HALF: part[k] = IN_HALF;
            lfr_pkg::ESZ_WORD: part[k] = IN_WORD;
            default:           part[k] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/lfr_reducer.sv
module lfr_reducer #(
   parameter int LANE_W    = 4,
   parameter int NUM_LANES = 8
) (
   input  logic [NUM_LANES*LANE_W-1:0] flags,
   input  logic [NUM_LANES-1:0]        part,
   input  logic                        any_mode,
   output logic [LANE_W-1:0]           folded
);
   logic [LANE_W-1:0] acc_all;
   logic [LANE_W-1:0] acc_any;

   always_comb begin
      acc_all = '1;
      acc_any = '0;
      for (int k = 0; k < NUM_LANES; k++) begin
         if (part[k]) begin
            acc_all = acc_all & flags[k*LANE_W +: LANE_W];
            acc_any = acc_any | flags[k*LANE_W +: LANE_W];
         end
      end
      folded = any_mode ? acc_any : acc_all;
   end
endmodule

// File: rtl/lfr_extract.sv
module lfr_extract #(
   parameter int LANE_W    = 4,
   parameter int NUM_LANES = 8
) (
   input  logic [NUM_LANES*LANE_W-1:0]    flags,
   input  logic [$clog2(NUM_LANES)-1:0]   sel,
   input  logic [1:0]                     size_code,
   output logic [LANE_W-1:0]              picked
);
   localparam int SEL_W = $clog2(NUM_LANES);
   localparam logic [SEL_W-1:0] HALF_MOD = SEL_W'((NUM_LANES >> 1) - 1);
   localparam logic [SEL_W-1:0] WORD_MOD = SEL_W'((NUM_LANES >> 2) - 1);
   localparam logic [SEL_W-1:0] HALF_OFS = SEL_W'(1);
   localparam logic [SEL_W-1:0] WORD_OFS = SEL_W'(3);

   logic [SEL_W-1:0] lane_idx;

   // Lane index = ((sel mod groups) * group size) + (group size - 1)
   always_comb begin
      case (size_code)
         lfr_pkg::ESZ_HALF: lane_idx = ((sel & HALF_MOD) << 1) | HALF_OFS;
         lfr_pkg::ESZ_WORD: lane_idx = ((sel & WORD_MOD) << 2) | WORD_OFS;
         default:           lane_idx = sel;
      endcase
      picked = flags[lane_idx*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/lane_flag_reduce.sv
module lane_flag_reduce #(
   parameter int LANE_W    = 4,
   parameter int NUM_LANES = 8,
   parameter int STAT_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          start,
   input  logic [NUM_LANES*LANE_W-1:0]   flags_in,
   input  logic [STAT_W-1:0]             status_in,
   input  logic [1:0]                    elem_size,
   input  logic [$clog2(NUM_LANES)-1:0]  lane_sel,
   input  logic [1:0]                    op_sel,
   output logic [STAT_W-1:0]             status_out,
   output logic                          done,
   output logic                          undef
);
   localparam int KEEP_W = STAT_W - LANE_W;

   if (LANE_W < 1 || STAT_W < LANE_W) begin : g_bad_width
      $error("lane_flag_reduce: STAT_W must be at least LANE_W");
   end
   if (NUM_LANES < 4 || (NUM_LANES & (NUM_LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane_flag_reduce: NUM_LANES must be a power of two, at least 4");
   end

   logic [NUM_LANES-1:0] part;
   logic [LANE_W-1:0]    folded;
   logic [LANE_W-1:0]    picked;
   logic [LANE_W-1:0]    group;
   logic [STAT_W-1:0]    next_word;
   logic                 refuse;

   lfr_lane_mask #(.NUM_LANES(NUM_LANES)) i_mask (
      .size_code (elem_size),
      .part      (part)
   );

   lfr_reducer #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_reduce (
      .flags    (flags_in),
      .part     (part),
      .any_mode (op_sel == lfr_pkg::FOP_ANY),
      .folded   (folded)
   );

   lfr_extract #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_extract (
      .flags     (flags_in),
      .sel       (lane_sel),
      .size_code (elem_size),
      .picked    (picked)
   );

   assign refuse = (elem_size == lfr_pkg::ESZ_RSVD) || (op_sel == lfr_pkg::FOP_RSVD);
   assign group  = (op_sel == lfr_pkg::FOP_PICK) ? picked : folded;

   if (KEEP_W > 0) begin : g_merge
      assign next_word = {group, status_in[KEEP_W-1:0]};
   end else begin : g_whole
      assign next_word = group;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         status_out <= '0;
         done       <= 1'b0;
         undef      <= 1'b0;
      end else begin
         done  <= start;
         undef <= start && refuse;
         if (start) begin
            status_out <= refuse ? status_in : next_word;
         end
      end
   end
endmodule

// File: rtl/lfr_chk.sv
module lfr_chk #(
   parameter int LANE_W    = 4,
   parameter int NUM_LANES = 8,
   parameter int STAT_W    = 32
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          start,
   input logic [NUM_LANES*LANE_W-1:0]   flags_in,
   input logic [STAT_W-1:0]             status_in,
   input logic [1:0]                    elem_size,
   input logic [$clog2(NUM_LANES)-1:0]  lane_sel,
   input logic [1:0]                    op_sel,
   input logic [STAT_W-1:0]             status_out,
   input logic                          done,
   input logic                          undef
);
   localparam int KEEP_W = STAT_W - LANE_W;

   // R2
   done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> done);

   // R2
   no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> !done);

   // R11
   undef_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      undef |-> done);

   // R10
   undef_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
      (start && elem_size == 2'd3) |=> (undef && status_out == $past(status_in)));

   // R6
   low_bits_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !undef) |-> status_out[KEEP_W-1:0] == $past(status_in[KEEP_W-1:0]));

   // R12
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> ($stable(status_out) && !undef));

   // R7
   byte_pick_chk: assert property (@(posedge clk) disable iff (rst)
      (start && elem_size == 2'd0 && op_sel == 2'd2) |=>
         status_out[STAT_W-1 -: LANE_W] == $past(flags_in[lane_sel*LANE_W +: LANE_W]));
endmodule

bind lane_flag_reduce lfr_chk #(
   .LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .STAT_W(STAT_W)
) i_chk (
   .clk(clk), .rst(rst), .start(start), .flags_in(flags_in),
   .status_in(status_in), .elem_size(elem_size), .lane_sel(lane_sel),
   .op_sel(op_sel), .status_out(status_out), .done(done), .undef(undef)
);

// File: tb/test_lane_flag_reduce.sv
module test_lane_flag_reduce;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] flags_in = '0;
   logic [31:0] status_in = '0;
   logic [1:0]  elem_size = '0;
   logic [2:0]  lane_sel = '0;
   logic [1:0]  op_sel = '0;
   logic [31:0] status_out;
   logic        done;
   logic        undef;

   always #2 clk = ~clk;

   lane_flag_reduce i_lane_flag_reduce (
      .clk(clk), .rst(rst), .start(start), .flags_in(flags_in),
      .status_in(status_in), .elem_size(elem_size), .lane_sel(lane_sel),
      .op_sel(op_sel), .status_out(status_out), .done(done), .undef(undef)
   );

   typedef struct {
      logic [31:0] st;
      logic        und;
      string       tag;
      int          cyc;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   logic [31:0] last_st = '0;
   bit          ended = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] nib(input logic [31:0] f, input int k);
      return f[4*k +: 4];
   endfunction

   // Model from the requirements
   function automatic exp_t model(input logic [31:0] f, input logic [31:0] s,
                                  input logic [1:0] sz, input logic [1:0] op, input logic [2:0] sel);
      exp_t e;
      logic [3:0] a, o, r;
      int pos;
      a = 4'hF; o = 4'h0;
      for (int k = 0; k < 8; k++) begin
         if (sz == 0 || (sz == 1 && (k % 2) == 1) || (sz == 2 && (k == 3 || k == 7))) begin
            a = a & nib(f, k);
            o = o | nib(f, k);
         end
      end
      if (sz == 0) pos = sel * 4;
      else if (sz == 1) pos = (sel % 4) * 8 + 4;
      else pos = (sel % 2) * 16 + 12;
      r = (op == 0) ? a : (op == 1) ? o : f[pos +: 4];
      if (sz == 3) begin
         e.st = s; e.und = 1'b1; e.tag = "R10";
      end else if (op == 3) begin
         e.st = s; e.und = 1'b1; e.tag = "R11";
      end else begin
         e.st = {r, s[27:0]}; e.und = 1'b0;
         if (op == 2) e.tag = (sz == 0) ? "R7" : (sz == 1) ? "R8" : "R9";
         else e.tag = (sz == 0) ? "R3" : (sz == 1) ? "R4" : "R5";
      end
      e.cyc = 0;
      return e;
   endfunction

   task automatic issue(input logic [31:0] f, input logic [31:0] s,
                        input logic [1:0] sz, input logic [1:0] op, input logic [2:0] sel);
      exp_t e;
      @(negedge clk);
      flags_in = f; status_in = s; elem_size = sz; op_sel = op; lane_sel = sel;
      start = 1'b1;
      e = model(f, s, sz, op, sel);
      e.cyc = cyc;
      last_st = e.st;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         flags_in = $urandom; status_in = $urandom;
         elem_size = 2'($urandom); op_sel = 2'($urandom); lane_sel = 3'($urandom);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Monitor: pops the scoreboard on every done pulse
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         cyc++;
         #1;
         if (!rst && done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 unexpected done", 32'(done), 32'd0);
            end else begin
               e = sb.pop_front();
               check(e.cyc + 1 == cyc, "R2 done timing", 32'(cyc), 32'(e.cyc + 1));
               check(status_out[31:28] == e.st[31:28], e.tag, status_out, e.st);
               check(status_out[27:0] == e.st[27:0], "R6", status_out, e.st);
               check(undef == e.und, "R11 undef flag", 32'(undef), 32'(e.und));
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, start ignored during reset
      rst = 1'b1;
      @(negedge clk);
      start = 1'b1; flags_in = 32'hFFFFFFFF; status_in = 32'hDEADBEEF;
      repeat (3) @(negedge clk);
      check(status_out == 0 && !done && !undef, "R1", {status_out[31:2], done, undef}, 32'd0);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      // R4: even lanes must not count for halfword
      issue(32'hF0F0F0F0, 32'h0123_4567, 2'd1, 2'd0, 3'd0);
      issue(32'hF0F0F0F0, 32'h0123_4567, 2'd0, 2'd0, 3'd0);
      issue(32'h0F0F0F0F, 32'h1111_1111, 2'd1, 2'd1, 3'd0);
      issue(32'h0F0F0F0F, 32'h1111_1111, 2'd0, 2'd1, 3'd0);
      // R5: only lanes 3 and 7 for word
      issue(32'hF000F000, 32'hABCD_EF01, 2'd2, 2'd0, 3'd0);
      issue(32'hF000F000, 32'hABCD_EF01, 2'd1, 2'd0, 3'd0);
      issue(32'h0FFF0FFF, 32'h5555_AAAA, 2'd2, 2'd1, 3'd0);
      issue(32'h0FFF0FFF, 32'h5555_AAAA, 2'd0, 2'd1, 3'd0);
      // R3: byte reductions
      issue(32'h9BDF_F9BD, 32'h0, 2'd0, 2'd0, 3'd0);
      issue(32'h0102_0408, 32'hFFFF_FFFF, 2'd0, 2'd1, 3'd0);
      idle(2);

      // R7, R8, R9: every selector under every size
      for (int sz = 0; sz < 3; sz++) begin
         for (int s = 0; s < 8; s++) begin
            issue(32'h7654_3210, 32'h0AAA_5555 ^ 32'(s), 2'(sz), 2'd2, 3'(s));
         end
      end
      idle(1);

      // R10, R11: reserved codes
      issue(32'hFFFF_FFFF, 32'h0765_4321, 2'd3, 2'd0, 3'd0);
      issue(32'h0, 32'hF765_4321, 2'd3, 2'd1, 3'd5);
      issue(32'hFFFF_FFFF, 32'h1357_9BDF, 2'd0, 2'd3, 3'd2);
      issue(32'hFFFF_FFFF, 32'h2468_ACE0, 2'd2, 2'd3, 3'd1);

      // R12: idle cycles with changing inputs leave the word alone
      idle(6);
      check(status_out == last_st && !done && !undef, "R12", status_out, last_st);

      // Random traffic, partly back-to-back
      for (int i = 0; i < 400; i++) begin
         issue($urandom, $urandom, 2'($urandom), 2'($urandom), 3'($urandom));
         if ($urandom_range(0, 2) == 0) idle(1 + $urandom_range(0, 2));
      end
      idle(3);
      check(sb.size() == 0, "R2 missing done", 32'(sb.size()), 32'd0);

      // R1: reset in mid run
      issue(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'd0, 2'd0, 3'd0);
      idle(2);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(status_out == 0 && !done && !undef, "R1", status_out, 32'd0);
      rst = 1'b0;
      idle(2);
      check(status_out == 0 && !done, "R12 after reset", status_out, 32'd0);

      finish_run();
   end
endmodule